// File: doc/BRIEF.md
# Fixed-Point Vector Lane Execution Datapath

This block is a single 32-bit execution lane of a vector coprocessor. Each issued element operation supplies an opcode, two source elements, a shift amount, a saturate flag and a predicate bit. The lane returns one result element with a write enable. The lane has no state that links one element to the next, so any number of copies can run side by side on one instruction.

Integer operations go through an ALU and then a clamp stage. The clamp either passes the low 32 bits of the exact result (wrap) or limits it to the signed or unsigned range. Multiplication takes a separate two-stage path. Stage one registers the full 64-bit signed product. Stage two applies an arithmetic right shift for fixed-point scaling and then clamps to signed 32 bits. The predicate gates only the write enable.

A two-state machine tracks the multiply path:
- `ST_IDLE`: no product is held in stage one.
- `ST_MUL1`: a product waits in stage one.

The transitions are:
- `ST_IDLE`→`ST_MUL1` on a multiply issue.
- `ST_MUL1`→`ST_MUL1` on back-to-back multiplies.
- `ST_MUL1`→`ST_IDLE` when no multiply is issued.

The output register loads the multiply result while in `ST_MUL1`. Otherwise it loads the ALU result of the current issue.

Top module: `vec_lane_unit`

## Requirements
- R1: `in_op` encodings are 0 add, 1 sub, 2 add unsigned, 3 sub unsigned, 4 and, 5 or, 6 xor, 7 min, 8 max, 9 min unsigned, 10 max unsigned, 11 absolute, 12 multiply-shift, and 13 to 15 reserved. Every non-multiply issue yields `out_valid` exactly one cycle after it is sampled.
- R2: A multiply-shift issue yields `out_valid` exactly two cycles after it is sampled, and multiplies may be issued on consecutive cycles.
- R3: With `in_sat` low, add and sub (signed or unsigned) return the low 32 bits of the exact sum or difference.
- R4: With `in_sat` high, signed add and sub clamp to 0x7FFFFFFF on positive overflow and to 0x80000000 on negative overflow.
- R5: With `in_sat` high, unsigned add clamps to 0xFFFFFFFF on carry, and unsigned sub clamps to 0 on borrow.
- R6: Min and max compare as two's complement; the unsigned forms compare as unsigned.
- R7: Absolute value negates negative operands. 0x80000000 gives 0x7FFFFFFF when `in_sat` is high and 0x80000000 when it is low.
- R8: And, or and xor are bitwise on the two operands.
- R9: Multiply-shift forms the 64-bit signed product and shifts it arithmetically right by `in_shamt` (0 to 31). It then returns either the signed-clamped value (`in_sat` high) or the low 32 bits.
- R10: `out_we` equals the predicate of the element being returned. The result value is delivered whatever the predicate, and `out_we` is never high without `out_valid`.
- R11: Reserved opcodes return `out_valid` with a result of 0 and `out_we` low.
- R12: While `rst_n` is low, `out_valid`, `out_we` and `out_result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Element operation issued this cycle |
| in_op | input | 4 | Opcode (see R1) |
| in_a | input | 32 | First source element |
| in_b | input | 32 | Second source element |
| in_shamt | input | 5 | Right-shift amount for multiply-shift |
| in_sat | input | 1 | Saturate instead of wrap |
| in_pred | input | 1 | Element predicate; low suppresses write |
| out_valid | output | 1 | Result element present |
| out_we | output | 1 | Write the result element back |
| out_result | output | 32 | Result element |

## Verification
The checker relies on one issue rule: a non-multiply operation never arrives in the cycle right after a multiply. If it did, its result would collide with the multiply result in the output register. The checker flags any break of this rule while the machine is in `ST_MUL1`. The bench driver keeps within the rule by remembering whether its last issue was a multiply. In that case it inserts one idle cycle before any other opcode, and this applies to both the directed cases and the mixed pseudo-random stream.

// File: rtl/vlane_pkg.sv
package vlane_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_ADDU  = 4'd2,
        OP_SUBU  = 4'd3,
        OP_AND   = 4'd4,
        OP_OR    = 4'd5,
        OP_XOR   = 4'd6,
        OP_MIN   = 4'd7,
        OP_MAX   = 4'd8,
        OP_MINU  = 4'd9,
        OP_MAXU  = 4'd10,
        OP_ABS   = 4'd11,
        OP_MULSH = 4'd12,
        OP_RSV13 = 4'd13,
        OP_RSV14 = 4'd14,
        OP_RSV15 = 4'd15
    } lane_op_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_MUL1 = 1'b1
    } lane_st_e;

    function automatic logic op_is_mul(input lane_op_e op);
        return op == OP_MULSH;
    endfunction

    function automatic logic op_is_reserved(input lane_op_e op);
        return (op == OP_RSV13) || (op == OP_RSV14) || (op == OP_RSV15);
    endfunction

    function automatic logic op_is_unsigned(input lane_op_e op);
        return (op == OP_ADDU) || (op == OP_SUBU) || (op == OP_MINU) || (op == OP_MAXU);
    endfunction

endpackage

// File: rtl/vlane_sat.sv
module vlane_sat #(
    parameter int W  = 32,
    parameter int IW = W + 2
) (
    input  logic signed [IW-1:0] wide,
    input  logic                 en,
    input  logic                 uns,
    output logic [W-1:0]         y
);
    localparam logic signed [IW-1:0] SMAX = {{(IW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [IW-1:0] SMIN = {{(IW-W+1){1'b1}}, {(W-1){1'b0}}};
    localparam logic signed [IW-1:0] UMAX = {{(IW-W){1'b0}}, {W{1'b1}}};
    localparam logic signed [IW-1:0] ZERO = '0;

    always_comb begin
        y = wide[W-1:0];
        if (en) begin
            if (uns) begin
                if (wide < ZERO)
                    y = '0;
                else if (wide > UMAX)
                    y = '1;
            end else begin
                if (wide > SMAX)
                    y = {1'b0, {(W-1){1'b1}}};
                else if (wide < SMIN)
                    y = {1'b1, {(W-1){1'b0}}};
            end
        end
    end
endmodule

// File: rtl/vlane_alu.sv
module vlane_alu
    import vlane_pkg::*;
#(
    parameter int W = 32
) (
    input  lane_op_e              op,
    input  logic [W-1:0]          a,
    input  logic [W-1:0]          b,
    output logic signed [W+1:0]   wide,
    output logic                  uns
);
    localparam int XW = W + 2;

    logic signed [XW-1:0] sa, sb, ua, ub;
    logic [W-1:0]         land, lor, lxor;

    assign sa   = {{2{a[W-1]}}, a};
    assign sb   = {{2{b[W-1]}}, b};
    assign ua   = {2'b00, a};
    assign ub   = {2'b00, b};
    assign land = a & b;
    assign lor  = a | b;
    assign lxor = a ^ b;
    assign uns  = op_is_unsigned(op);

    always_comb begin
        unique case (op)
            OP_ADD:  wide = sa + sb;
            OP_SUB:  wide = sa - sb;
            OP_ADDU: wide = ua + ub;
            OP_SUBU: wide = ua - ub;
            OP_AND:  wide = {{2{land[W-1]}}, land};
            OP_OR:   wide = {{2{lor[W-1]}}, lor};
            OP_XOR:  wide = {{2{lxor[W-1]}}, lxor};
            OP_MIN:  wide = ($signed(a) < $signed(b)) ? sa : sb;
            OP_MAX:  wide = ($signed(a) > $signed(b)) ? sa : sb;
            OP_MINU: wide = (a < b) ? ua : ub;
            OP_MAXU: wide = (a > b) ? ua : ub;
            OP_ABS:  wide = a[W-1] ? -sa : sa;
            default: wide = '0;
        endcase
    end
endmodule

// File: rtl/vlane_mulshift.sv
module vlane_mulshift #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [SW-1:0] shamt,
    input  logic          sat,
    input  logic          pred,
    output logic [W-1:0]  res,
    output logic          pred_q
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] prod_d, prod_q, shifted;
    logic [SW-1:0]        sh_q;
    logic                 sat_q;

    assign prod_d = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q <= '0;
            sh_q   <= '0;
            sat_q  <= 1'b0;
            pred_q <= 1'b0;
        end else if (ld) begin
            prod_q <= prod_d;
            sh_q   <= shamt;
            sat_q  <= sat;
            pred_q <= pred;
        end
    end

    assign shifted = prod_q >>> sh_q;

    vlane_sat #(.W(W), .IW(PW)) u_mul_sat (
        .wide (shifted),
        .en   (sat_q),
        .uns  (1'b0),
        .y    (res)
    );
endmodule

// File: rtl/vec_lane_unit.sv
module vec_lane_unit
    import vlane_pkg::*;
#(
    parameter int W = 32,
    localparam int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    in_op,
    input  logic [W-1:0]  in_a,
    input  logic [W-1:0]  in_b,
    input  logic [SW-1:0] in_shamt,
    input  logic          in_sat,
    input  logic          in_pred,
    output logic          out_valid,
    output logic          out_we,
    output logic [W-1:0]  out_result
);
    lane_op_e             op_e;
    logic                 issue_mul, issue_alu, rsv;
    logic signed [W+1:0]  alu_wide;
    logic                 alu_uns;
    logic [W-1:0]         alu_y, mul_y;
    logic                 mul_pred;
    lane_st_e             state_q, state_d;

    assign op_e      = lane_op_e'(in_op);
    assign issue_mul = in_valid && op_is_mul(op_e);
    assign issue_alu = in_valid && !op_is_mul(op_e);
    assign rsv       = op_is_reserved(op_e);

    vlane_alu #(.W(W)) u_alu (
        .op   (op_e),
        .a    (in_a),
        .b    (in_b),
        .wide (alu_wide),
        .uns  (alu_uns)
    );

    vlane_sat #(.W(W), .IW(W + 2)) u_alu_sat (
        .wide (alu_wide),
        .en   (in_sat),
        .uns  (alu_uns),
        .y    (alu_y)
    );

    vlane_mulshift #(.W(W), .SW(SW)) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (issue_mul),
        .a      (in_a),
        .b      (in_b),
        .shamt  (in_shamt),
        .sat    (in_sat),
        .pred   (in_pred),
        .res    (mul_y),
        .pred_q (mul_pred)
    );

    // next-state logic for the multiply tracker
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = issue_mul ? ST_MUL1 : ST_IDLE;
            ST_MUL1: state_d = issue_mul ? ST_MUL1 : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_we     <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= 1'b0;
            out_we    <= 1'b0;
            unique case (state_q)
                ST_MUL1: begin
                    out_valid  <= 1'b1;
                    out_we     <= mul_pred;
                    out_result <= mul_y;
                end
                ST_IDLE: begin
                    if (issue_alu) begin
                        out_valid  <= 1'b1;
                        out_we     <= in_pred && !rsv;
                        out_result <= alu_y;
                    end
                end
                default: begin
                    out_valid <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/vlane_chk.sv
module vlane_chk
    import vlane_pkg::*;
#(
    parameter int W = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [3:0]    in_op,
    input logic          in_a_msb,
    input logic          in_b_msb,
    input logic          in_sat,
    input logic          in_pred,
    input logic          out_valid,
    input logic          out_we,
    input logic [W-1:0]  out_result,
    input lane_st_e      state_q
);
    logic is_mul_in, is_rsv_in, idle;
    assign is_mul_in = (in_op == 4'd12);
    assign is_rsv_in = (in_op == 4'd13) || (in_op == 4'd14) || (in_op == 4'd15);
    assign idle      = (state_q == ST_IDLE);

    // R10
    we_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> out_valid);

    // R1
    alu_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !is_mul_in && idle |=> out_valid);

    // R2
    mul_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && is_mul_in |=> ##1 out_valid);

    // R2
    issue_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUL1) && in_valid |-> is_mul_in);

    // R4
    sadd_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_op == 4'd0) && in_sat && !in_a_msb && !in_b_msb && idle
        |=> !out_result[W-1]);

    // R7
    abs_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_op == 4'd11) && in_sat && idle |=> !out_result[W-1]);

    // R10
    pred_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_pred && !is_mul_in && idle |=> !out_we);

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && is_rsv_in && idle |=> out_valid && !out_we && (out_result == '0));
endmodule

bind vec_lane_unit vlane_chk #(.W(W)) u_vlane_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_a_msb   (in_a[W-1]),
    .in_b_msb   (in_b[W-1]),
    .in_sat     (in_sat),
    .in_pred    (in_pred),
    .out_valid  (out_valid),
    .out_we     (out_we),
    .out_result (out_result),
    .state_q    (state_q)
);

// File: tb/vec_lane_unit_bench.sv
module vec_lane_unit_bench;
    localparam longint SMAXL = 64'sh7FFF_FFFF;
    localparam longint SMINL = -64'sh8000_0000;
    localparam longint UMAXL = 64'shFFFF_FFFF;

    typedef struct {
        logic [31:0] res;
        logic        we;
        int          due;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [31:0] in_a = '0, in_b = '0;
    logic [4:0]  in_shamt = '0;
    logic        in_sat = 1'b0, in_pred = 1'b0;
    logic        out_valid, out_we;
    logic [31:0] out_result;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    bit   last_mul = 1'b0;

    vec_lane_unit u_vec_lane_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .in_shamt(in_shamt), .in_sat(in_sat),
        .in_pred(in_pred), .out_valid(out_valid), .out_we(out_we),
        .out_result(out_result)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] clamp_s(input longint v, input logic sat);
        if (sat && v > SMAXL) return 32'h7FFF_FFFF;
        if (sat && v < SMINL) return 32'h8000_0000;
        return 32'(v);
    endfunction

    function automatic logic [31:0] clamp_u(input longint v, input logic sat);
        if (sat && v > UMAXL) return 32'hFFFF_FFFF;
        if (sat && v < 0) return 32'h0;
        return 32'(v);
    endfunction

    function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [4:0] sh,
                                          input logic sat);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint ua = longint'({32'h0, a});
        longint ub = longint'({32'h0, b});
        longint p;
        case (op)
            4'd0:  return clamp_s(sa + sb, sat);
            4'd1:  return clamp_s(sa - sb, sat);
            4'd2:  return clamp_u(ua + ub, sat);
            4'd3:  return clamp_u(ua - ub, sat);
            4'd4:  return a & b;
            4'd5:  return a | b;
            4'd6:  return a ^ b;
            4'd7:  return (sa < sb) ? a : b;
            4'd8:  return (sa > sb) ? a : b;
            4'd9:  return (ua < ub) ? a : b;
            4'd10: return (ua > ub) ? a : b;
            4'd11: return clamp_s((sa < 0) ? -sa : sa, sat);
            4'd12: begin
                p = sa * sb;
                p = p >>> sh;
                return clamp_s(p, sat);
            end
            default: return 32'h0;
        endcase
    endfunction

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
        last_mul = 1'b0;
    endtask

    task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] sh, input logic sat, input logic pred,
                         input string tag);
        exp_t e;
        if (last_mul && op != 4'd12) idle(1);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
        in_shamt = sh; in_sat = sat; in_pred = pred;
        e.res = model(op, a, b, sh, sat);
        e.we  = pred && (op < 4'd13);
        e.due = cyc + ((op == 4'd12) ? 2 : 1);
        e.tag = tag;
        sb_q.push_back(e);
        last_mul = (op == 4'd12);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R1 unexpected out_valid: actual result %h, expected none", out_result);
            end else begin
                exp_t e;
                bit   bad = 1'b0;
                e = sb_q.pop_front();
                n_chk++;
                if (cyc != e.due) begin
                    bad = 1'b1;
                    $display("FAIL %s (R1/R2 latency): actual cycle %0d, expected %0d", e.tag, cyc, e.due);
                end
                if (out_result !== e.res) begin
                    bad = 1'b1;
                    $display("FAIL %s: actual result %h, expected %h", e.tag, out_result, e.res);
                end
                if (out_we !== e.we) begin
                    bad = 1'b1;
                    $display("FAIL %s (R10): actual we %b, expected %b", e.tag, out_we, e.we);
                end
                if (bad) n_bad++;
            end
        end
    end

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout, expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        n_chk++;
        if (out_valid !== 1'b0 || out_we !== 1'b0 || out_result !== 32'h0) begin
            n_bad++;
            $display("FAIL R12: actual %b/%b/%h, expected 0/0/00000000", out_valid, out_we, out_result);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R8 bitwise
        issue(4'd4, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 0, 1, "R8 and");
        issue(4'd5, 32'hF000_0001, 32'h0000_1100, 0, 1, 1, "R8 or");
        issue(4'd6, 32'hAAAA_5555, 32'hFFFF_0000, 0, 0, 1, "R8 xor");
        // R3 wrap
        issue(4'd0, 32'h7FFF_FFFF, 32'h1, 0, 0, 1, "R3 add wrap");
        issue(4'd2, 32'hFFFF_FFFF, 32'h2, 0, 0, 1, "R3 addu wrap");
        issue(4'd1, 32'h0, 32'h1, 0, 0, 1, "R3 sub wrap");
        issue(4'd3, 32'h3, 32'h5, 0, 0, 1, "R3 subu wrap");
        // R4 signed clamp
        issue(4'd0, 32'h7FFF_FFFF, 32'h1, 0, 1, 1, "R4 add pos clamp");
        issue(4'd1, 32'h8000_0000, 32'h1, 0, 1, 1, "R4 sub neg clamp");
        issue(4'd0, 32'h8000_0000, 32'hFFFF_FFFF, 0, 1, 1, "R4 add neg clamp");
        issue(4'd0, 32'h5, 32'hFFFF_FFFD, 0, 1, 1, "R4 add in range");
        // R5 unsigned clamp
        issue(4'd2, 32'hFFFF_FFF0, 32'h20, 0, 1, 1, "R5 addu clamp");
        issue(4'd3, 32'h3, 32'h5, 0, 1, 1, "R5 subu clamp");
        // R6 min/max
        issue(4'd7, 32'hFFFF_FFFF, 32'h1, 0, 0, 1, "R6 min");
        issue(4'd8, 32'hFFFF_FFFF, 32'h1, 0, 0, 1, "R6 max");
        issue(4'd9, 32'hFFFF_FFFF, 32'h1, 0, 0, 1, "R6 minu");
        issue(4'd10, 32'hFFFF_FFFF, 32'h1, 0, 1, 1, "R6 maxu");
        // R7 abs
        issue(4'd11, 32'hFFFF_FFFB, 32'h0, 0, 0, 1, "R7 abs neg");
        issue(4'd11, 32'h8000_0000, 32'h0, 0, 1, 1, "R7 abs min sat");
        issue(4'd11, 32'h8000_0000, 32'h0, 0, 0, 1, "R7 abs min wrap");
        // R9 multiply-shift, R2 back-to-back
        issue(4'd12, 32'h3, 32'h4, 0, 0, 1, "R9 mul plain");
        issue(4'd12, 32'h0001_0000, 32'h0001_0000, 16, 1, 1, "R9 mul q16");
        issue(4'd12, 32'h7FFF_FFFF, 32'h2, 0, 1, 1, "R9 mul clamp");
        issue(4'd12, 32'h7FFF_FFFF, 32'h2, 0, 0, 1, "R9 mul wrap");
        issue(4'd12, 32'hFFFF_FFFD, 32'h5, 1, 0, 1, "R9 mul neg shift");
        issue(4'd12, 32'h8000_0000, 32'h7FFF_FFFF, 31, 1, 1, "R9 mul shift31");
        issue(4'd12, 32'h8000_0000, 32'h8000_0000, 0, 1, 1, "R2 mul chain clamp");
        // R10 predicate
        issue(4'd0, 32'h10, 32'h20, 0, 0, 0, "R10 alu pred off");
        issue(4'd12, 32'h6, 32'h7, 0, 0, 0, "R10 mul pred off");
        issue(4'd1, 32'h10, 32'h4, 0, 0, 1, "R10 pred on");
        // R11 reserved
        issue(4'd13, 32'h1234, 32'h5678, 0, 1, 1, "R11 rsv13");
        issue(4'd14, 32'hFFFF_FFFF, 32'h1, 0, 0, 1, "R11 rsv14");
        issue(4'd15, 32'h8000_0000, 32'h8000_0000, 3, 1, 1, "R11 rsv15");
        idle(3);
        // mixed stream, R1 and R2 ordering
        for (int i = 0; i < 60; i++) begin
            issue(4'($urandom_range(0, 15)), $urandom, $urandom,
                  5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), "R1 R2 mixed");
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        idle(6);
        n_chk++;
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL R1: actual %0d results missing, expected 0", sb_q.size());
        end
        summary();
    end
endmodule